// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block gives a host a window onto a 256-byte bank of configuration registers through only two byte-wide I/O addresses. The host first writes a register number to the index address; each later read or write at the data address then reaches the register that number selects. The selected number stays latched, so a run of data accesses can work on one register without writing the index again.

Only a sparse set of registers in the upper part of the bank accepts writes. All registers below 0xE0, and a scattered group above it, ignore data writes. Two registers hold serial-port base selections and accept a single supported value each. A write of any other value to either one leaves it unchanged and raises a one-cycle error flag. An external enable input decides whether the block answers at all. While it is low, both addresses behave as if nothing were mapped there.

Top module: `sioCfgPort`

## Requirements
- R1: A write strobe at address INDEX_PORT (default 0x3F0) while enabled loads the write byte into the index latch. The latch changes on no other event, and a read at INDEX_PORT returns its value.
- R2: A read strobe at address DATA_PORT (default 0x3F1) while enabled returns the register at the latched index on ioRdData. The value appears after the clock edge that samples the strobe and holds until the next read strobe.
- R3: After reset the index latch is 0x00. Registers 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE and 0xE8=0xBE, and every other register is 0x00.
- R4: A data write while enabled stores the byte into the indexed register when the index is one of 0xE0–0xE3, 0xE6, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 or 0xFC. Indexes 0xE7 and 0xE8 also store it, subject to R6.
- R5: A data write to any other index leaves the register unchanged and raises no error.
- R6: Register 0xE7 stores only 0xFE and register 0xE8 stores only 0xBE. Any other value leaves the register unchanged, and errFlag goes high for exactly the one cycle after that write's clock edge.
- R7: While cfgEnable is low, writes at both ports change neither the index latch nor any register, and reads at either port return 0xFF.
- R8: A read strobe at any address other than the two ports returns 0xFF, and a write strobe there changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | Maps the two ports when high |
| ioAddr | input | ADDR_W | I/O address of the current strobe |
| ioWrData | input | 8 | Write byte |
| ioWrStb | input | 1 | One-cycle write strobe |
| ioRdStb | input | 1 | One-cycle read strobe |
| ioRdData | output | 8 | Registered read byte |
| errFlag | output | 1 | One-cycle pulse on an unsupported base-selection write |

## Verification
Each result has one register stage, so it is due one cycle after its strobe. A write reaches the bank at the edge that samples it. A read byte is valid after the edge that samples the read strobe. The error pulse is high only in the cycle after the edge that samples the bad write. The bench drives every strobe on a falling edge for one cycle and samples at the next falling edge, exactly one edge later. It sweeps all 256 indexes for reset value, write acceptance and readback, and checks the error flag after every write.

// File: rtl/sioCfgPkg.sv
package sioCfgPkg;

  localparam int unsigned REG_W     = 8;
  localparam int unsigned REG_COUNT = 256;
  localparam int unsigned IDX_W     = $clog2(REG_COUNT);
  localparam int unsigned HI_BASE   = 224;
  localparam int unsigned HI_SPAN   = REG_COUNT - HI_BASE;

  // bit k set: index HI_BASE+k accepts data writes
  localparam logic [HI_SPAN-1:0] HI_WRITE_MASK = 32'h1157_C1CF;

  localparam logic [IDX_W-1:0] BASE_SEL_A = 8'hE7;
  localparam logic [IDX_W-1:0] BASE_SEL_B = 8'hE8;
  localparam logic [REG_W-1:0] BASE_VAL_A = 8'hFE;
  localparam logic [REG_W-1:0] BASE_VAL_B = 8'hBE;

  typedef struct packed {
    logic idxWr;
    logic idxRd;
    logic dataWr;
    logic dataRd;
    logic missRd;
  } cfgStrobes_t;

  function automatic logic isWritable(input logic [IDX_W-1:0] idx);
    logic [IDX_W-1:0] off;
    off = idx - IDX_W'(HI_BASE);
    return (32'(idx) >= HI_BASE) && HI_WRITE_MASK[off[4:0]];
  endfunction

  function automatic logic valueLegal(input logic [IDX_W-1:0] idx,
                                      input logic [REG_W-1:0] val);
    if (idx == BASE_SEL_A) return val == BASE_VAL_A;
    if (idx == BASE_SEL_B) return val == BASE_VAL_B;
    return 1'b1;
  endfunction

  function automatic logic [REG_W-1:0] powerOnValue(input logic [IDX_W-1:0] idx);
    case (idx)
      8'hE0:   return 8'h3C;
      8'hE2:   return 8'h03;
      8'hE3:   return 8'hFC;
      8'hE6:   return 8'hDE;
      BASE_SEL_A: return BASE_VAL_A;
      BASE_SEL_B: return BASE_VAL_B;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/sioCfgCtrl.sv
module sioCfgCtrl
  import sioCfgPkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h03F0,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 16'h03F1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWrStb,
  input  logic              ioRdStb,
  output cfgStrobes_t       stb
);

  logic idxHit;
  logic dataHit;

  assign idxHit  = cfgEnable && (ioAddr == INDEX_PORT);
  assign dataHit = cfgEnable && (ioAddr == DATA_PORT);

  always_comb begin
    stb        = '0;
    stb.idxWr  = ioWrStb && idxHit;
    stb.dataWr = ioWrStb && dataHit;
    stb.idxRd  = ioRdStb && idxHit;
    stb.dataRd = ioRdStb && dataHit;
    stb.missRd = ioRdStb && !idxHit && !dataHit;
  end

  // R7: nothing reaches the bank while unmapped
  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |-> !(stb.idxWr || stb.dataWr || stb.idxRd || stb.dataRd));

  // R8: every read strobe is answered by exactly one read source
  assert_read_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    ioRdStb |-> $onehot({stb.idxRd, stb.dataRd, stb.missRd}));

  assert_write_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.idxWr, stb.dataWr}));

endmodule

// File: rtl/sioCfgData.sv
module sioCfgData
  import sioCfgPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cfgStrobes_t      stb,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             errFlag
);

  logic [IDX_W-1:0] idxReg;
  logic [REG_W-1:0] cfgBank [REG_COUNT];
  logic [REG_W-1:0] selByte;
  logic             slotOpen;
  logic             valOk;

  assign selByte  = cfgBank[idxReg];
  assign slotOpen = isWritable(idxReg);
  assign valOk    = valueLegal(idxReg, wrData);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idxReg <= '0;
    else if (stb.idxWr) idxReg <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) cfgBank[i] <= powerOnValue(IDX_W'(i));
    end else if (stb.dataWr && slotOpen && valOk) begin
      cfgBank[idxReg] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errFlag <= 1'b0;
    else       errFlag <= stb.dataWr && slotOpen && !valOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rdData <= '1;
    else if (stb.dataRd) rdData <= selByte;
    else if (stb.idxRd)  rdData <= idxReg;
    else if (stb.missRd) rdData <= '1;
  end

  assert_index_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !stb.idxWr |=> $stable(idxReg));

  assert_protect_drop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.dataWr && !slotOpen) |=> ($stable(selByte) && !errFlag));

  assert_err_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> ($past(stb.dataWr) && $stable(selByte)));

  assert_miss_ff_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.missRd |=> (rdData == 8'hFF));

  assert_read_value_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.dataRd |=> (rdData == $past(selByte)));

endmodule

// File: rtl/sioCfgPort.sv
module sioCfgPort
  import sioCfgPkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h03F0,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 16'h03F1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [7:0]        ioWrData,
  input  logic              ioWrStb,
  input  logic              ioRdStb,
  output logic [7:0]        ioRdData,
  output logic              errFlag
);

  cfgStrobes_t stb;

  sioCfgCtrl #(
    .ADDR_W    (ADDR_W),
    .INDEX_PORT(INDEX_PORT),
    .DATA_PORT (DATA_PORT)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgEnable(cfgEnable),
    .ioAddr   (ioAddr),
    .ioWrStb  (ioWrStb),
    .ioRdStb  (ioRdStb),
    .stb      (stb)
  );

  sioCfgData uData (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (ioWrData),
    .rdData (ioRdData),
    .errFlag(errFlag)
  );

endmodule

// File: tb/sioCfgPort_test.sv
module sioCfgPort_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgEnable = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [7:0]  ioWrData = '0;
  logic        ioWrStb = 1'b0;
  logic        ioRdStb = 1'b0;
  logic [7:0]  ioRdData;
  logic        errFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] model [256];

  always #5 clk = ~clk;

  sioCfgPort uut (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .ioAddr(ioAddr),
    .ioWrData(ioWrData), .ioWrStb(ioWrStb), .ioRdStb(ioRdStb),
    .ioRdData(ioRdData), .errFlag(errFlag)
  );

  function automatic bit benchWritable(int i);
    if (i < 'hE0) return 0;
    if (i == 'hE4 || i == 'hE5 || i == 'hF3 || i == 'hF5 || i == 'hF7) return 0;
    if (i >= 'hE9 && i <= 'hED) return 0;
    if (i >= 'hF9 && i <= 'hFB) return 0;
    if (i >= 'hFD) return 0;
    return 1;
  endfunction

  function automatic logic [7:0] benchReset(int i);
    case (i)
      'hE0: return 8'h3C; 'hE2: return 8'h03; 'hE3: return 8'hFC;
      'hE6: return 8'hDE; 'hE7: return 8'hFE; 'hE8: return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  // strobe held for one cycle; the sample point is one edge later
  task automatic busWrite(logic [15:0] a, logic [7:0] d, output logic err);
    @(negedge clk);
    ioAddr = a; ioWrData = d; ioWrStb = 1'b1;
    @(negedge clk);
    ioWrStb = 1'b0;
    err = errFlag;
  endtask

  task automatic busRead(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioRdStb = 1'b1;
    @(negedge clk);
    ioRdStb = 1'b0;
    d = ioRdData;
  endtask

  initial begin
    logic [7:0] rd;
    logic       e;
    logic [7:0] v;
    repeat (3) @(negedge clk);
    check("R3 reset rdData idle", ioRdData, 8'hFF);
    check("R3 reset errFlag", {7'd0, errFlag}, 8'h00);
    rstN = 1'b1;
    cfgEnable = 1'b1;

    busRead(16'h03F0, rd);
    check("R3 index reset / R1 index read", rd, 8'h00);
    busRead(16'h03F1, rd);
    check("R2 read at reset index", rd, 8'h00);

    for (int i = 0; i < 256; i++) begin
      busWrite(16'h03F0, 8'(i), e);
      busRead(16'h03F1, rd);
      check("R3 power-on value", rd, benchReset(i));
      model[i] = benchReset(i);
    end

    for (int i = 0; i < 256; i++) begin
      v = 8'(i) ^ 8'hA5;
      busWrite(16'h03F0, 8'(i), e);
      busRead(16'h03F0, rd);
      if (i % 16 == 3) check("R1 index readback", rd, 8'(i));
      busWrite(16'h03F1, v, e);
      if (i == 'hE7 || i == 'hE8) begin
        check("R6 error pulse on bad value", {7'd0, e}, 8'h01);
      end else begin
        check("R5 no error on ordinary write", {7'd0, e}, 8'h00);
        if (benchWritable(i)) model[i] = v;
      end
      @(negedge clk);
      if (i == 'hE7) check("R6 error pulse one cycle", {7'd0, errFlag}, 8'h00);
      busRead(16'h03F1, rd);
      check(benchWritable(i) ? "R4 writable store" : "R5 protected drop", rd, model[i]);
      busRead(16'h03F1, rd);
      if (i == 'hF0) check("R1 index held across data accesses", rd, model[i]);
    end

    busWrite(16'h03F0, 8'hE7, e);
    busWrite(16'h03F1, 8'hFE, e);
    check("R6 legal value no error", {7'd0, e}, 8'h00);
    busRead(16'h03F1, rd);
    check("R6 legal value kept", rd, 8'hFE);
    busWrite(16'h03F0, 8'hE8, e);
    busWrite(16'h03F1, 8'hBE, e);
    check("R6 legal value no error", {7'd0, e}, 8'h00);
    busWrite(16'h03F1, 8'h00, e);
    check("R6 bad zero value error", {7'd0, e}, 8'h01);
    busRead(16'h03F1, rd);
    check("R6 bad value left unchanged", rd, 8'hBE);

    busWrite(16'h03F0, 8'hE1, e);
    cfgEnable = 1'b0;
    busWrite(16'h03F0, 8'hE2, e);
    busWrite(16'h03F1, 8'h77, e);
    busRead(16'h03F1, rd);
    check("R7 disabled data read", rd, 8'hFF);
    busRead(16'h03F0, rd);
    check("R7 disabled index read", rd, 8'hFF);
    cfgEnable = 1'b1;
    busRead(16'h03F0, rd);
    check("R7 index untouched while disabled", rd, 8'hE1);
    busRead(16'h03F1, rd);
    check("R7 entry untouched while disabled", rd, model['hE1]);

    busRead(16'h03F2, rd);
    check("R8 unmapped read", rd, 8'hFF);
    busWrite(16'h03F2, 8'h55, e);
    busWrite(16'h0000, 8'h66, e);
    busRead(16'h03F0, rd);
    check("R8 unmapped write leaves index", rd, 8'hE1);
    busRead(16'h03F1, rd);
    check("R8 unmapped write leaves entry", rd, model['hE1]);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule